// File: doc/BRIEF.md
# Zoned Associative Address Translator

This block translates a virtual address through a small, fully associative set of translation entries. Each entry holds a tag word (page number, page size, valid flag), a data word (physical page number, execute and write permission, zone selector) and an 8-bit process tag. A lookup request carries the virtual address, the access kind, the privilege level of the requester, the current process ID and a zone protection word. The block answers one cycle later with a status of hit, miss or protection fault. For a matching entry it also returns the physical page number, the page-size code and the index of that entry.

Pages range from 1 KiB to 16 MiB, and each entry sets its own size. The size fixes how many address bits take part in the compare. Each entry points into a table of sixteen 2-bit zone codes. A zone code can hide the entry from user accesses, or grant execute and write permission over the entry's own bits. The entries are loaded through a plain write port. The translator does no page walking, does no refill and has no caching around it.

Top module: `tlb_zone_xlate`

## Requirements
- R1: While reset is high, and after it until the first request, `rsp_valid` is 0 and the status, page number, size and index outputs are all zero.
- R2: A request sampled at a clock edge produces `rsp_valid`=1 with its result after that same edge. `rsp_valid` is 0 after any edge where `req_valid` was 0. Back-to-back requests each get their own result.
- R3: An entry's size code sits in tag bits 9:7 and selects a page of 1024·4^code bytes: codes 0..7 give 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M. The address matches only when it equals the tag in every bit at or above log2(page size).
- R4: An entry takes part only when tag bit 6 (valid) is 1. Writing entry `wr_idx` with `wr_en` replaces its tag, data and process tag from the next cycle on, and reset clears every valid bit.
- R5: An entry whose process tag is 0 matches every process. Any other process tag must equal `cur_pid`.
- R6: When several entries are candidates, the one with the lowest index is taken.
- R7: The zone selector is data bits 7:4. Its code is bits (31−2·sel):(30−2·sel) of `zone_prot`. Code 0 makes the entry invisible to user requests, and the search then goes on to later entries. Supervisor requests use the entry's own bits under code 0.
- R8: Permission bits are data bit 9 (execute) and data bit 8 (write). Code 1 uses them unchanged. Code 2 sets both for supervisor requests only. Code 3 sets both for every request.
- R9: A selector greater than parameter `ZONE_CNT`, or any selector when `ZONES_EN`=0, behaves as code 1.
- R10: Access kinds are 0 read, 1 write and 2 fetch; 3 is treated as a read. On the chosen entry, a write without write permission or a fetch without execute permission gives status 2 (fault). No later entry is tried. A read never faults.
- R11: Status codes are 0 miss, 1 hit and 2 fault. On hit or fault, `rsp_ppn` is data bits 31:10, `rsp_size` is the size code and `rsp_idx` is the entry index. On a miss all three are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | $clog2(ENTRIES) | Entry to load |
| wr_tag | input | 32 | Tag word to load |
| wr_data | input | 32 | Data word to load |
| wr_tid | input | 8 | Process tag to load |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user request, 0 = supervisor |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone codes, selector 0 at bits 31:30 |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_status | output | 2 | 0 miss, 1 hit, 2 fault |
| rsp_ppn | output | 22 | Physical page number of the chosen entry |
| rsp_size | output | 3 | Page-size code of the chosen entry |
| rsp_idx | output | $clog2(ENTRIES) | Index of the chosen entry |

## Verification
The bench builds two copies with 16 entries and a zone count of 7. The first copy has zones enabled and the second has them off, and both receive the same stimulus. With zone count 7, selector 9 lies out of range, so the out-of-range rule can be checked next to an in-range selector. The zones-off copy sees every zone pattern and must always behave as code 1. Sixteen entries keep the priority and hidden-entry cases short while still spanning several index bits.

// File: rtl/tlb_zx_pkg.sv
package tlb_zx_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 10;
  localparam int PPN_W    = WORD_W - PAGE_LSB;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam logic [1:0] ST_MISS  = 2'd0;
  localparam logic [1:0] ST_HIT   = 2'd1;
  localparam logic [1:0] ST_FAULT = 2'd2;

  localparam int TAG_VALID_BIT = 6;
  localparam int DAT_WR_BIT    = 8;
  localparam int DAT_EX_BIT    = 9;

  // compare mask for a size code: page is 1024 * 4**code bytes
  function automatic logic [WORD_W-1:0] size_mask(input logic [2:0] code);
    logic [4:0] sh;
    sh = 5'(PAGE_LSB) + {1'b0, code, 1'b0};
    return ~((WORD_W'(1) << sh) - WORD_W'(1));
  endfunction
endpackage

// File: rtl/tlb_zx_entry.sv
module tlb_zx_entry
  import tlb_zx_pkg::*;
#(
  parameter int ZONE_CNT = 15,
  parameter bit ZONES_EN = 1'b1
) (
  input  logic [WORD_W-1:0] tag,
  input  logic [WORD_W-1:0] data,
  input  logic [7:0]        tid,
  input  logic [WORD_W-1:0] vaddr,
  input  logic [7:0]        pid,
  input  logic [WORD_W-1:0] zprot,
  input  logic              user,
  input  logic [1:0]        acc,
  output logic              cand,
  output logic              fault
);
  logic              valid, addr_hit, pid_hit, hidden, can_wr, can_ex;
  logic [3:0]        zsel;
  logic [4:0]        zsh;
  logic [WORD_W-1:0] zshifted;
  logic [1:0]        zcode;
  logic              spare_unused;

  assign spare_unused = ^{tag[5:0], data[3:0]};

  assign valid    = tag[TAG_VALID_BIT];
  assign addr_hit = ((vaddr ^ tag) & size_mask(tag[9:7])) == '0;
  assign pid_hit  = (tid == 8'd0) || (tid == pid);

  assign zsel     = data[7:4];
  assign zsh      = 5'd30 - {zsel, 1'b0};
  assign zshifted = zprot >> zsh;

  generate
    if (ZONES_EN) begin : g_zones
      assign zcode = (int'(zsel) > ZONE_CNT) ? 2'd1 : zshifted[1:0];
    end else begin : g_nozones
      logic zs_unused;
      assign zs_unused = ^zshifted;
      assign zcode = 2'd1;
    end
  endgenerate

  assign hidden = (zcode == 2'd0) && user;
  assign cand   = valid && addr_hit && pid_hit && !hidden;

  assign can_wr = data[DAT_WR_BIT] || (zcode == 2'd3) || (zcode == 2'd2 && !user);
  assign can_ex = data[DAT_EX_BIT] || (zcode == 2'd3) || (zcode == 2'd2 && !user);

  assign fault  = (acc == ACC_WR && !can_wr) || (acc == ACC_FX && !can_ex);
endmodule

// File: rtl/tlb_zx_first.sv
module tlb_zx_first #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any   = |req;
    grant = any ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
  end
endmodule

// File: rtl/tlb_zone_xlate.sv
module tlb_zone_xlate
  import tlb_zx_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int ZONE_CNT = 15,
  parameter bit ZONES_EN = 1'b1,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [31:0]       wr_tag,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        wr_tid,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [7:0]        cur_pid,
  input  logic [31:0]       zone_prot,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [21:0]       rsp_ppn,
  output logic [2:0]        rsp_size,
  output logic [IW-1:0]     rsp_idx
);
  logic [WORD_W-1:0] tag_q  [ENTRIES];
  logic [WORD_W-1:0] data_q [ENTRIES];
  logic [7:0]        tid_q  [ENTRIES];

  logic [ENTRIES-1:0] cand_vec, fault_vec, grant_vec, valid_vec;
  logic               any_hit;
  logic [IW-1:0]      pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        tid_q[i]  <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
      tid_q[wr_idx]  <= wr_tid;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign valid_vec[g] = tag_q[g][TAG_VALID_BIT];
      tlb_zx_entry #(.ZONE_CNT(ZONE_CNT), .ZONES_EN(ZONES_EN)) u_ent (
        .tag   (tag_q[g]),
        .data  (data_q[g]),
        .tid   (tid_q[g]),
        .vaddr (req_vaddr),
        .pid   (cur_pid),
        .zprot (zone_prot),
        .user  (req_user),
        .acc   (req_acc),
        .cand  (cand_vec[g]),
        .fault (fault_vec[g])
      );
    end
  endgenerate

  tlb_zx_first #(.N(ENTRIES)) u_first (
    .req   (cand_vec),
    .grant (grant_vec),
    .any   (any_hit),
    .idx   (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_ppn    <= '0;
      rsp_size   <= '0;
      rsp_idx    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (any_hit) begin
          rsp_status <= fault_vec[pick] ? ST_FAULT : ST_HIT;
          rsp_ppn    <= data_q[pick][WORD_W-1:PAGE_LSB];
          rsp_size   <= tag_q[pick][9:7];
          rsp_idx    <= pick;
        end else begin
          rsp_status <= ST_MISS;
          rsp_ppn    <= '0;
          rsp_size   <= '0;
          rsp_idx    <= '0;
        end
      end
    end
  end

  // R2
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));
  // R6
  grant_is_cand_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_vec & ~cand_vec) == '0);
  // R4
  invalid_nomatch_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_vec & ~valid_vec) == '0);
  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_MISS) |-> (rsp_ppn == '0 && rsp_size == '0 && rsp_idx == '0));
  // R11
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_status != 2'd3);
endmodule

// File: tb/tlb_zone_xlate_tb.sv
module tlb_zone_xlate_tb;
  localparam int N  = 16;
  localparam int ZC = 7;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_tag = '0, wr_data = '0;
  logic [7:0]  wr_tid = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic [31:0] zone_prot = 32'h5555_5555;

  logic a_valid, b_valid;
  logic [1:0] a_st, b_st;
  logic [21:0] a_ppn, b_ppn;
  logic [2:0] a_sz, b_sz;
  logic [IW-1:0] a_idx, b_idx;

  always #4 clk = ~clk;

  tlb_zone_xlate #(.ENTRIES(N), .ZONE_CNT(ZC), .ZONES_EN(1'b1)) u_dut (
    .clk, .rst, .wr_en, .wr_idx, .wr_tag, .wr_data, .wr_tid,
    .req_valid, .req_vaddr, .req_acc, .req_user, .cur_pid, .zone_prot,
    .rsp_valid(a_valid), .rsp_status(a_st), .rsp_ppn(a_ppn), .rsp_size(a_sz), .rsp_idx(a_idx));

  tlb_zone_xlate #(.ENTRIES(N), .ZONE_CNT(ZC), .ZONES_EN(1'b0)) u_dut_nz (
    .clk, .rst, .wr_en, .wr_idx, .wr_tag, .wr_data, .wr_tid,
    .req_valid, .req_vaddr, .req_acc, .req_user, .cur_pid, .zone_prot,
    .rsp_valid(b_valid), .rsp_status(b_st), .rsp_ppn(b_ppn), .rsp_size(b_sz), .rsp_idx(b_idx));

  // behavioural reference
  logic [31:0] m_tag [N];
  logic [31:0] m_data [N];
  logic [7:0]  m_tid [N];
  logic        e_valid = 1'b0;
  logic [30:0] e_a = '0, e_b = '0;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  function automatic logic [30:0] ref_look(input logic [31:0] va, input logic [1:0] acc,
      input logic usr, input logic [7:0] pid, input logic [31:0] zp, input bit zen);
    for (int i = 0; i < N; i++) begin
      logic [31:0] t, d, msk;
      int sel, zc;
      bit w, x;
      t = m_tag[i];
      d = m_data[i];
      if (!t[6]) continue;
      msk = ~((32'd1 << (10 + 2 * int'(t[9:7]))) - 32'd1);
      if ((va & msk) != (t & msk)) continue;
      if (m_tid[i] != 8'd0 && m_tid[i] != pid) continue;
      sel = int'(d[7:4]);
      zc = int'((zp >> (30 - 2 * sel)) & 32'd3);
      if (!zen || sel > ZC) zc = 1;
      if (zc == 0 && usr) continue;
      w = d[8];
      x = d[9];
      if (zc == 3 || (zc == 2 && !usr)) begin w = 1'b1; x = 1'b1; end
      return {((acc == 2'd1 && !w) || (acc == 2'd2 && !x)) ? 2'd2 : 2'd1,
              d[31:10], t[9:7], 4'(i)};
    end
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; m_tid[i] = '0; end
      e_valid = 1'b0; e_a = '0; e_b = '0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        e_a = ref_look(req_vaddr, req_acc, req_user, cur_pid, zone_prot, 1'b1);
        e_b = ref_look(req_vaddr, req_acc, req_user, cur_pid, zone_prot, 1'b0);
      end
      if (wr_en) begin
        m_tag[wr_idx] = wr_tag; m_data[wr_idx] = wr_data; m_tid[wr_idx] = wr_tid;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if ({a_valid, a_st, a_ppn, a_sz, a_idx} !== {e_valid, e_a}) begin
        errors++;
        $display("FAIL %s zones-on: actual %h expected %h", cur_req,
                 {a_valid, a_st, a_ppn, a_sz, a_idx}, {e_valid, e_a});
      end
      checks++;
      if ({b_valid, b_st, b_ppn, b_sz, b_idx} !== {e_valid, e_b}) begin
        errors++;
        $display("FAIL %s zones-off: actual %h expected %h", cur_req,
                 {b_valid, b_st, b_ppn, b_sz, b_idx}, {e_valid, e_b});
      end
    end
  end

  task automatic put(input int i, input logic [31:0] t, input logic [31:0] d, input logic [7:0] id);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(i); wr_tag = t; wr_data = d; wr_tid = id;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic usr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk_tag(input logic [31:0] va, input int code);
    return (va & 32'hFFFF_FC00) | (32'(code) << 7) | 32'h40;
  endfunction

  function automatic logic [31:0] mk_data(input logic [21:0] ppn, input bit ex, input bit w, input int sel);
    return {ppn, ex, w, 4'(sel), 4'h0};
  endfunction

  initial begin
    int sels [2];
    sels[0] = 3;
    sels[1] = 9;
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4: empty table misses, then valid bit gating
    cur_req = "R4";
    look(32'h4000_0000, 2'd0, 1'b0);
    put(0, mk_tag(32'h4000_0000, 0) & ~32'h40, mk_data(22'h11111, 1, 1, 0), 8'd0);
    look(32'h4000_0000, 2'd0, 1'b0);

    // R3: each page size, last byte inside and first byte beyond
    cur_req = "R3";
    for (int c = 0; c < 8; c++) begin
      int unsigned sz;
      sz = 32'd1024 << (2 * c);
      put(0, mk_tag(32'h4000_0000, c), mk_data(22'(32'h2A000 + c), 1, 1, 0), 8'd0);
      look(32'h4000_0000 + sz - 1, 2'd0, 1'b0);
      look(32'h4000_0000 + sz, 2'd0, 1'b0);
      look(32'h3FFF_FFFF, 2'd0, 1'b0);
    end

    // R5: process tags
    cur_req = "R5";
    put(0, mk_tag(32'h5000_0000, 1), mk_data(22'h00AB1, 1, 1, 0), 8'h3C);
    cur_pid = 8'h3C; look(32'h5000_0123, 2'd0, 1'b0);
    cur_pid = 8'h3D; look(32'h5000_0123, 2'd0, 1'b0);
    put(0, mk_tag(32'h5000_0000, 1), mk_data(22'h00AB1, 1, 1, 0), 8'h00);
    look(32'h5000_0123, 2'd0, 1'b0);

    // R6: lowest index wins; back-to-back requests (R2)
    cur_req = "R6";
    put(3, mk_tag(32'h6000_0000, 2), mk_data(22'h00033, 1, 1, 0), 8'd0);
    put(9, mk_tag(32'h6000_0000, 4), mk_data(22'h00099, 1, 1, 0), 8'd0);
    cur_req = "R2";
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h6000_0100; req_acc = 2'd0; req_user = 1'b0;
    @(negedge clk);
    req_vaddr = 32'h6002_0000;
    @(negedge clk);
    req_valid = 1'b0;
    cur_req = "R6";
    put(3, 32'h0, 32'h0, 8'd0);
    look(32'h6000_0100, 2'd0, 1'b0);

    // R7 R8 R9 R10: zones, hidden entries, permission faults
    put(2, mk_tag(32'h1234_8000, 2), mk_data(22'h00222, 0, 0, 0), 8'd0);
    put(5, mk_tag(32'h1234_8000, 2), mk_data(22'h00555, 1, 1, 0), 8'd0);
    for (int s = 0; s < 2; s++) begin
      put(2, mk_tag(32'h1234_8000, 2), mk_data(22'h00222, 0, 0, sels[s]), 8'd0);
      for (int z = 0; z < 4; z++) begin
        zone_prot = 32'h5555_5555;
        zone_prot[31 - 2 * sels[s % 2] % 32 -: 2] = 2'(z);
        if (sels[s] > 15) zone_prot = 32'h5555_5555;
        for (int u = 0; u < 2; u++) begin
          for (int a = 0; a < 4; a++) begin
            case (z)
              0: cur_req = "R7";
              1, 2: cur_req = "R8";
              default: cur_req = (a == 0) ? "R10" : "R8";
            endcase
            if (s == 1) cur_req = "R9";
            look(32'h1234_9ABC, 2'(a), 1'(u));
          end
        end
      end
    end
    // R10: fault on own bits without retrying later entries
    cur_req = "R10";
    zone_prot = 32'h5555_5555;
    put(2, mk_tag(32'h1234_8000, 2), mk_data(22'h00222, 0, 0, 0), 8'd0);
    look(32'h1234_9ABC, 2'd1, 1'b1);
    look(32'h1234_9ABC, 2'd2, 1'b0);
    look(32'h1234_9ABC, 2'd0, 1'b1);

    // R11: result fields and miss zeros
    cur_req = "R11";
    look(32'h1234_9ABC, 2'd0, 1'b0);
    look(32'h7777_0000, 2'd0, 1'b0);
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule